// File: doc/BRIEF.md
# Row-Indexed Partial-Sum Accumulator with Ping-Pong Banks

This block sums a stream of products into per-row totals for one horizontal strip of a blocked sparse matrix. Every product arrives with a row index. The block reads that row's running total, adds the product, and writes the result back to the same row. The path from read to write-back is a pipeline of `ACC_LAT` access stages followed by `ADD_LAT` adder stages. The row address travels through the pipeline beside the data, so the write-back always reaches the row that was read.

A new product whose row is already somewhere in that pipeline would read a stale total. The block therefore withholds `in_ready` until that row has been written back. Products for other rows keep flowing at one per cycle.

Totals live in two independent banks. At any moment one bank accumulates and the other drains. A pulse on `strip_end` asks for a bank swap. The swap waits until the pipeline is empty and the previous drain has finished. After the swap, the retired bank is streamed out one row per beat in ascending row order, and each entry is cleared as it leaves. Meanwhile, products for the next strip accumulate in the other bank without stalling.

The block is controlled by two small state machines:

- The strip machine has two states. It moves from `ST_ACCUM` to `ST_SWAP_WAIT` on `strip_end`. It moves from `ST_SWAP_WAIT` back to `ST_ACCUM` on the swap edge, which happens when the pipeline is empty and the drain machine is idle.
- The drain machine has two states. It moves from `DR_IDLE` to `DR_STREAM` on the swap edge. It returns from `DR_STREAM` to `DR_IDLE` when the beat for the last row is accepted.

Top module: `rowsum_accumulator`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and every entry of both banks is zero. No drain beat appears before the first `strip_end`, and the first drain returns zero for all rows.
- R2: Each accepted product (`in_valid` and `in_ready` both 1 at a rising edge) is added to the total of row `in_row`. Addition wraps modulo 2^DATA_W. The value drained for a row equals the wrapped sum of that strip's products for that row.
- R3: Two accepted products with the same row are at least ACC_LAT+ADD_LAT+1 clock edges apart. With the defaults, a product offered right after another one for the same row is accepted exactly 17 cycles after it.
- R4: Products with distinct rows that are not in flight are accepted on consecutive cycles, with no stall.
- R5: From the cycle after `strip_end`, `in_ready` is 0 until the swap. The swap happens on the first edge at which the pipeline is empty and no drain is running. With no drain running, the first drain beat is visible ACC_LAT+ADD_LAT+1 cycles after the last accepted product. If a drain is running, the next drain's first beat is visible on the second cycle after the running drain's final accepted beat.
- R6: A drain presents rows 0 to ROWS-1 in ascending order on `out_row`, advancing one row per accepted beat. With `out_ready` held at 1, the ROWS beats occupy consecutive cycles.
- R7: Each drained entry is cleared to zero. A bank that is reused two strips later drains only the sums of its new strip.
- R8: While a drain is running, products for the new strip are accepted at full rate.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_row` and `out_sum` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A product is offered |
| in_ready | output | 1 | Product can be taken this cycle (no row conflict, no pending swap) |
| in_row | input | IDX_W | Row index of the offered product |
| in_data | input | DATA_W | Product value |
| strip_end | input | 1 | One-cycle request to end the current strip and swap banks |
| out_valid | output | 1 | A drained row total is presented |
| out_ready | input | 1 | Consumer accepts the presented total |
| out_row | output | IDX_W | Row index of the presented total |
| out_sum | output | DATA_W | Presented row total |

## Verification
Four rules are checked by assertions on every cycle:

- the minimum spacing between accepted products with the same row index;
- the closing of the input after an end-of-strip request;
- the row order and the stall behaviour of the drain stream;
- the absence of drain beats before the first request.

The directed scenarios are needed for the numerical results: the wrapped sums, the clearing of a reused bank, the exact swap latency after the pipeline empties, full-rate accumulation while the other bank drains, and the chaining of one drain into the next.

// File: rtl/rowsum_pkg.sv
package rowsum_pkg;

    // Strip-level control: accumulating, or waiting to swap banks.
    typedef enum logic {
        ST_ACCUM,
        ST_SWAP_WAIT
    } strip_state_t;

    // Drain control for the retired bank.
    typedef enum logic {
        DR_IDLE,
        DR_STREAM
    } drain_state_t;

endpackage

// File: rtl/rowsum_bank.sv
// One bank of row totals.
// The accumulate side has a read port and a write port.
// The drain side reads one entry and may clear it.
// The two sides never target the same bank at the same time.
module rowsum_bank #(
    parameter int DATA_W = 64,
    parameter int ROWS   = 128,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  acc_raddr,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_waddr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [IDX_W-1:0]  drn_addr,
    output logic [DATA_W-1:0] drn_rdata,
    input  logic              drn_clr
);

    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                mem[i] <= '0;
            end
        end else if (acc_we) begin
            mem[acc_waddr] <= acc_wdata;
        end else if (drn_clr) begin
            mem[drn_addr] <= '0;
        end
    end

    assign acc_rdata = mem[acc_raddr];
    assign drn_rdata = mem[drn_addr];

endmodule

// File: rtl/rowsum_pipe.sv
// Delay line of the read-modify-write loop.
// Stages 0 .. ACC_LAT-1 are the access stages; the row total is read at the
// last of them. Stages ACC_LAT .. TOT-1 model the adder latency.
// The last stage drives the write-back.
module rowsum_pipe #(
    parameter int DATA_W  = 64,
    parameter int ROWS    = 128,
    parameter int ACC_LAT = 2,
    parameter int ADD_LAT = 14,
    localparam int IDX_W  = $clog2(ROWS),
    localparam int TOT    = ACC_LAT + ADD_LAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_fire,
    input  logic [IDX_W-1:0]  in_row,
    input  logic [DATA_W-1:0] in_data,
    output logic              hazard,
    output logic              empty,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wb_we,
    output logic [IDX_W-1:0]  wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    logic              st_v   [TOT];
    logic [IDX_W-1:0]  st_row [TOT];
    logic [DATA_W-1:0] st_val [TOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TOT; k++) begin
                st_v[k]   <= 1'b0;
                st_row[k] <= '0;
                st_val[k] <= '0;
            end
        end else begin
            st_v[0]   <= in_fire;
            st_row[0] <= in_row;
            st_val[0] <= in_data;
            for (int k = 1; k < TOT; k++) begin
                st_v[k]   <= st_v[k-1];
                st_row[k] <= st_row[k-1];
                if (k == ACC_LAT) begin
                    st_val[k] <= st_val[k-1] + rd_data;
                end else begin
                    st_val[k] <= st_val[k-1];
                end
            end
        end
    end

    // Compare the offered row against every occupied stage.
    always_comb begin
        hazard = 1'b0;
        empty  = 1'b1;
        for (int k = 0; k < TOT; k++) begin
            if (st_v[k]) begin
                empty = 1'b0;
                if (st_row[k] == in_row) begin
                    hazard = 1'b1;
                end
            end
        end
    end

    assign rd_addr = st_row[ACC_LAT-1];
    assign wb_we   = st_v[TOT-1];
    assign wb_addr = st_row[TOT-1];
    assign wb_data = st_val[TOT-1];

endmodule

// File: rtl/rowsum_ctrl.sv
// Strip and drain state machines, drain pointer and active-bank selector.
module rowsum_ctrl #(
    parameter int ROWS   = 128,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strip_end,
    input  logic             pipe_empty,
    input  logic             out_ready,
    output logic             act_bank,
    output logic             strip_pend,
    output logic             drn_valid,
    output logic [IDX_W-1:0] drn_ptr,
    output logic             drn_clr
);
    import rowsum_pkg::*;

    strip_state_t     st_q, st_d;
    drain_state_t     dr_q, dr_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             bank_q, bank_d;
    logic             swap;
    logic             last_beat;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ACCUM;
            dr_q   <= DR_IDLE;
            ptr_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            dr_q   <= dr_d;
            ptr_q  <= ptr_d;
            bank_q <= bank_d;
        end
    end

    // Next state.
    always_comb begin
        swap      = (st_q == ST_SWAP_WAIT) && pipe_empty && (dr_q == DR_IDLE);
        last_beat = (dr_q == DR_STREAM) && out_ready && (ptr_q == IDX_W'(ROWS - 1));
        st_d      = st_q;
        dr_d      = dr_q;
        ptr_d     = ptr_q;
        bank_d    = bank_q;

        unique case (st_q)
            ST_ACCUM: begin
                if (strip_end) begin
                    st_d = ST_SWAP_WAIT;
                end
            end
            ST_SWAP_WAIT: begin
                if (swap) begin
                    st_d   = ST_ACCUM;
                    bank_d = ~bank_q;
                end
            end
        endcase

        unique case (dr_q)
            DR_IDLE: begin
                if (swap) begin
                    dr_d  = DR_STREAM;
                    ptr_d = '0;
                end
            end
            DR_STREAM: begin
                if (out_ready) begin
                    ptr_d = ptr_q + 1'b1;
                    if (last_beat) begin
                        dr_d = DR_IDLE;
                    end
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        strip_pend = (st_q == ST_SWAP_WAIT);
        drn_valid  = (dr_q == DR_STREAM);
        drn_clr    = (dr_q == DR_STREAM) && out_ready;
        drn_ptr    = ptr_q;
        act_bank   = bank_q;
    end

endmodule

// File: rtl/rowsum_accumulator.sv
// Top level: delay-line pipeline, two row-total banks, strip/drain control.
module rowsum_accumulator #(
    parameter int DATA_W  = 64,
    parameter int ROWS    = 128,
    parameter int ACC_LAT = 2,
    parameter int ADD_LAT = 14,
    localparam int IDX_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_row,
    input  logic [DATA_W-1:0] in_data,
    input  logic              strip_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_row,
    output logic [DATA_W-1:0] out_sum
);

    logic              in_fire;
    logic              hazard;
    logic              pipe_empty;
    logic [IDX_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wb_we;
    logic [IDX_W-1:0]  wb_addr;
    logic [DATA_W-1:0] wb_data;
    logic              act_bank;
    logic              strip_pend;
    logic              drn_valid;
    logic [IDX_W-1:0]  drn_ptr;
    logic              drn_clr;
    logic [DATA_W-1:0] bank_acc_rd [2];
    logic [DATA_W-1:0] bank_drn_rd [2];

    assign in_ready = !strip_pend && !hazard;
    assign in_fire  = in_valid && in_ready;

    rowsum_pipe #(
        .DATA_W (DATA_W),
        .ROWS   (ROWS),
        .ACC_LAT(ACC_LAT),
        .ADD_LAT(ADD_LAT)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_fire(in_fire),
        .in_row (in_row),
        .in_data(in_data),
        .hazard (hazard),
        .empty  (pipe_empty),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .wb_we  (wb_we),
        .wb_addr(wb_addr),
        .wb_data(wb_data)
    );

    rowsum_ctrl #(
        .ROWS(ROWS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strip_end (strip_end),
        .pipe_empty(pipe_empty),
        .out_ready (out_ready),
        .act_bank  (act_bank),
        .strip_pend(strip_pend),
        .drn_valid (drn_valid),
        .drn_ptr   (drn_ptr),
        .drn_clr   (drn_clr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic is_act;
        assign is_act = (act_bank == 1'(b));

        rowsum_bank #(
            .DATA_W(DATA_W),
            .ROWS  (ROWS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_raddr(rd_addr),
            .acc_rdata(bank_acc_rd[b]),
            .acc_we   (wb_we && is_act),
            .acc_waddr(wb_addr),
            .acc_wdata(wb_data),
            .drn_addr (drn_ptr),
            .drn_rdata(bank_drn_rd[b]),
            .drn_clr  (drn_clr && !is_act)
        );
    end

    assign rd_data   = bank_acc_rd[act_bank];
    assign out_sum   = bank_drn_rd[~act_bank];
    assign out_row   = drn_ptr;
    assign out_valid = drn_valid;

endmodule

// File: rtl/rowsum_accumulator_chk.sv
module rowsum_accumulator_chk #(
    parameter int DATA_W  = 64,
    parameter int ROWS    = 128,
    parameter int ACC_LAT = 2,
    parameter int ADD_LAT = 14,
    localparam int IDX_W  = $clog2(ROWS),
    localparam int TOT    = ACC_LAT + ADD_LAT,
    localparam int GAP_W  = $clog2(TOT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [IDX_W-1:0]  in_row,
    input logic              strip_end,
    input logic              out_valid,
    input logic              out_ready,
    input logic [IDX_W-1:0]  out_row,
    input logic [DATA_W-1:0] out_sum
);

    // Edges since each row was last accepted, saturating at TOT.
    logic [GAP_W-1:0] gap [ROWS];
    logic             seen_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                gap[i] <= GAP_W'(TOT);
            end
            seen_end <= 1'b0;
        end else begin
            for (int i = 0; i < ROWS; i++) begin
                if (in_valid && in_ready && (in_row == IDX_W'(i))) begin
                    gap[i] <= '0;
                end else if (gap[i] < GAP_W'(TOT)) begin
                    gap[i] <= gap[i] + 1'b1;
                end
            end
            if (strip_end) begin
                seen_end <= 1'b1;
            end
        end
    end

    // R1: nothing is drained before the first end-of-strip request.
    a_r1_quiet_before_end: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_end |-> !out_valid);

    // R3: same-row acceptances keep the read-modify-write spacing.
    a_r3_row_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (gap[in_row] >= GAP_W'(TOT)));

    // R5: the input closes right after an end-of-strip request.
    a_r5_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
        strip_end |=> !in_ready);

    // R6: every drain starts at row zero.
    a_r6_first_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_row == '0));

    // R6: rows advance by one per accepted beat.
    a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (out_row != IDX_W'(ROWS - 1)))
        |=> (out_valid && (out_row == IDX_W'($past(out_row) + 1'b1))));

    // R9: a stalled beat holds.
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_sum)));

endmodule

bind rowsum_accumulator rowsum_accumulator_chk #(
    .DATA_W (DATA_W),
    .ROWS   (ROWS),
    .ACC_LAT(ACC_LAT),
    .ADD_LAT(ADD_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_row   (in_row),
    .strip_end(strip_end),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_row  (out_row),
    .out_sum  (out_sum)
);

// File: tb/sim_rowsum_accumulator.sv
module sim_rowsum_accumulator;
    localparam int DATA_W  = 64;
    localparam int ROWS    = 128;
    localparam int ACC_LAT = 2;
    localparam int ADD_LAT = 14;
    localparam int IDX_W   = 7;
    localparam int TOT     = ACC_LAT + ADD_LAT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [IDX_W-1:0]  in_row = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              strip_end = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [IDX_W-1:0]  out_row;
    logic [DATA_W-1:0] out_sum;

    rowsum_accumulator #(
        .DATA_W(DATA_W), .ROWS(ROWS), .ACC_LAT(ACC_LAT), .ADD_LAT(ADD_LAT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_data(in_data), .strip_end(strip_end),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_sum(out_sum)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DATA_W-1:0] exp_sum  [ROWS];
    logic [DATA_W-1:0] snap     [2][ROWS];
    logic [DATA_W-1:0] last_got [ROWS];
    int first_c [8];
    int last_c  [8];
    int n_end   = 0;
    int n_drain = 0;
    int mon_idx = 0;
    int acc_cyc = 0;
    logic seen_first = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] want);
        n_tests++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, want);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Drain monitor: order (R6), values (R2), stall hold (R9).
    logic              hold_v = 1'b0;
    logic [IDX_W-1:0]  hold_row;
    logic [DATA_W-1:0] hold_sum;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (hold_v) begin
                chk("R9", "valid held", 64'(out_valid), 64'd1);
                chk("R9", "row held", 64'(out_row), 64'(hold_row));
                chk("R9", "sum held", out_sum, hold_sum);
            end
            hold_v = 1'b0;
            if (out_valid) begin
                if (mon_idx == 0 && !seen_first) begin
                    first_c[n_drain] = cyc;
                    seen_first = 1'b1;
                end
                if (out_ready) begin
                    chk("R6", "drain row order", 64'(out_row), 64'(mon_idx));
                    chk("R2", "drained sum", out_sum, snap[n_drain % 2][mon_idx]);
                    last_got[mon_idx] = out_sum;
                    mon_idx++;
                    if (mon_idx == ROWS) begin
                        last_c[n_drain] = cyc;
                        n_drain++;
                        mon_idx = 0;
                        seen_first = 1'b0;
                    end
                end else begin
                    hold_v   = 1'b1;
                    hold_row = out_row;
                    hold_sum = out_sum;
                end
            end
        end
    end

    // Offer one product; returns at the negedge after it is accepted.
    task automatic send(input int row, input logic [63:0] val);
        in_valid = 1'b1;
        in_row   = IDX_W'(row);
        in_data  = val;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        exp_sum[row] = exp_sum[row] + val;
    endtask

    task automatic go_idle();
        in_valid = 1'b0;
    endtask

    task automatic end_strip();
        strip_end = 1'b1;
        for (int r = 0; r < ROWS; r++) begin
            snap[n_end % 2][r] = exp_sum[r];
            exp_sum[r] = '0;
        end
        n_end++;
        @(negedge clk);
        strip_end = 1'b0;
    endtask

    task automatic wait_drains(input int n);
        while (n_drain < n) begin
            @(negedge clk);
            #3;
        end
    endtask

    task automatic t_reset();
        int nz;
        @(negedge clk);
        #1;
        chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        repeat (3) @(negedge clk);
        chk("R1", "no drain before strip end", 64'(out_valid), 64'd0);
        end_strip();
        wait_drains(1);
        nz = 0;
        for (int r = 0; r < ROWS; r++) if (last_got[r] != '0) nz++;
        chk("R1", "banks start at zero", 64'(nz), 64'd0);
    endtask

    task automatic t_accumulate();
        int prev;
        int last_acc;
        @(negedge clk);
        for (int r = 0; r < ROWS; r++) begin
            prev = acc_cyc;
            send(r, 64'(r * 3 + 1));
            if (r > 0) chk("R4", "distinct rows back to back", 64'(acc_cyc - prev), 64'd1);
        end
        send(5, 64'hFFFF_FFFF_FFFF_FFF0);      // 16 + this wraps to 0
        send(127, 64'h1_0000_0000);
        send(64, 64'h8000_0000_0000_0000);
        go_idle();
        last_acc = acc_cyc;
        end_strip();
        #1;
        chk("R5", "input closed after strip end", 64'(in_ready), 64'd0);
        wait_drains(2);
        chk("R5", "swap latency after last product", 64'(first_c[1] - last_acc), 64'(TOT + 1));
        chk("R6", "drain beats contiguous", 64'(last_c[1] - first_c[1]), 64'(ROWS - 1));
        chk("R2", "wrap-around sum", last_got[5], 64'd0);
        chk("R2", "multi-product row", last_got[127], 64'h1_0000_0000 + 64'd382);
    endtask

    task automatic t_hazard();
        int first;
        @(negedge clk);
        send(9, 64'd100);
        first = acc_cyc;
        send(9, 64'd23);
        chk("R3", "same row spacing", 64'(acc_cyc - first), 64'(TOT + 1));
        send(10, 64'd7);
        first = acc_cyc;
        send(11, 64'd8);
        chk("R4", "different row after stall", 64'(acc_cyc - first), 64'd1);
        send(9, 64'd5);
        chk("R3", "third same row spacing", 64'(acc_cyc - first + 1), 64'(TOT + 1));
        go_idle();
    endtask

    task automatic t_overlap();
        int k;
        int prev;
        end_strip();                     // drain of the hazard strip
        while (!out_valid) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        fork
            begin
                k = 0;
                while (n_drain < 3) begin
                    @(negedge clk);
                    out_ready = (k % 3 != 2);
                    k++;
                end
                out_ready = 1'b1;
            end
            begin
                for (int r = 20; r < 60; r++) begin
                    prev = acc_cyc;
                    send(r, 64'(r + 1000));
                    if (r > 20) chk("R8", "full rate during drain", 64'(acc_cyc - prev), 64'd1);
                    if (r == 40) chk("R8", "drain still running", 64'(out_valid), 64'd1);
                end
                go_idle();
                end_strip();
                #1;
                chk("R5", "drain busy while swap waits", 64'(out_valid), 64'd1);
                chk("R5", "input closed while swap waits", 64'(in_ready), 64'd0);
            end
        join
        wait_drains(4);
        chk("R5", "next drain follows previous", 64'(first_c[3] - last_c[2]), 64'd2);
        chk("R7", "reused bank row 0 cleared", last_got[0], 64'd0);
        chk("R7", "reused bank row 100 cleared", last_got[100], 64'd0);
        chk("R2", "new strip row 33", last_got[33], 64'd1033);
        @(negedge clk);
        #1;
        chk("R1", "idle after drains", 64'(out_valid), 64'd0);
        chk("R1", "input open when idle", 64'(in_ready), 64'd1);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) exp_sum[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_accumulate();
        t_hazard();
        t_overlap();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule